// File: doc/BRIEF.md
# Serial Game Controller Port

This block is the processor-facing side of two serial game-controller ports. Each port presents eight button states that software pulls out one bit per read. A single strobe register, shared by both ports, decides whether the ports are being loaded or being shifted out. While the strobe is held, reads show the live state of the first button. When the strobe is dropped, each port's eight buttons are captured, and successive reads then walk through them in a fixed order.

The block sits on a simple synchronous processor bus as a slave. Address bit 0 picks the port. Bits 7:1 of the read byte do not come from the ports: they are filled from the high byte of the bus address, filtered through an open-bus mask, as an undriven data bus would show. Read data is registered. It appears the cycle after the read strobe and holds until the next read of a port.

Top module: `pad_port_if`

## Requirements
- R1: After reset the strobe is inactive, both bit indices are 0, both captured button vectors are zero, and `rdata_o` is 0x00, so the first read of either port returns bit 0 = 0.
- R2: A write to address 0x4016 with `wdata_i[0]`=1 makes the strobe active for both ports. While the strobe is active, a read of either port returns that port's live button input bit 0 (button A), and the read does not move the index.
- R3: A write to 0x4016 with `wdata_i[0]`=0 makes the strobe inactive and sets both ports' indices to 0. If the strobe was active before that write, both button input vectors are captured at the same clock edge.
- R4: While the strobe is inactive, a read returns the captured bit at the port's current index and then adds one to that index. Bits 0 to 7 of a button vector are, in order: A, B, Select, Start, Up, Down, Left, Right.
- R5: Once a port has given out all eight bits, every further read of that port returns 1 until a write of 0 to 0x4016 sets its index back to 0.
- R6: A read of 0x4016 reads port 1 (`pad0_btn_i`) and a read of 0x4017 reads port 2 (`pad1_btn_i`). A read advances only the port it addresses.
- R7: The read byte is registered and appears the cycle after `rd_i`. Bits 7:1 are bits 7:1 of (`addr_i[15:8]` & `BUS_MASK`), and bit 0 is the button bit. With the default mask 0xE0, a port read returns 0x40 or 0x41.
- R8: `rdata_o` holds its value in cycles with no port read. Reads of other addresses and writes to any address other than 0x4016 (0x4017 included) change neither the strobe, the indices, nor the captured buttons.
- R9: Button inputs are captured only on the strobe's change from active to inactive. Later input changes do not reach shifted-out bits. A write of 0 while the strobe is already inactive sets the indices to 0 but keeps the earlier capture.
- R10: When a read and a strobe write occur in the same cycle, the read returns data from the state before the write, and the write alone sets the next strobe, index and capture state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data; only bit 0 is used, at the strobe address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Registered read data |
| pad0_btn_i | input | 8 | Port 1 buttons, bit 0 = A to bit 7 = Right, 1 = pressed |
| pad1_btn_i | input | 8 | Port 2 buttons, same order |

## Verification
The two ports are given different, asymmetric button patterns, so a swapped port, a reversed bit order or a shared index each produce a wrong bit at a known read. The inputs are inverted right after each capture, which separates reads of the captured state from reads of the live inputs. Reads are made while the strobe is held with button A toggled, across the full eight-bit drain and past it, after a write of 0 when the strobe is already clear, around accesses to neighbouring addresses, and with a read and a strobe write in the same cycle in both directions. Each of these shows whether the pre-write state, the live input or the latched state fed the answer.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
  localparam int unsigned PAD_BTN_N = 8;

  typedef enum logic [2:0] {
    BTN_A     = 3'd0,
    BTN_B     = 3'd1,
    BTN_SEL   = 3'd2,
    BTN_START = 3'd3,
    BTN_UP    = 3'd4,
    BTN_DOWN  = 3'd5,
    BTN_LEFT  = 3'd6,
    BTN_RIGHT = 3'd7
  } btn_idx_e;
endpackage

// File: rtl/pad_bus_decode.sv
module pad_bus_decode #(
  parameter logic [15:0] BASE_ADDR = 16'h4016
) (
  input  logic [15:0] addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic        wbit_i,
  output logic        strb_wr_o,
  output logic        strb_set_o,
  output logic        rd_hit_o,
  output logic        rd_sel_o
);
  localparam logic [14:0] PAIR_TAG = BASE_ADDR[15:1];

  logic pair_hit;
  assign pair_hit   = (addr_i[15:1] == PAIR_TAG);
  assign strb_wr_o  = wr_i && pair_hit && (addr_i[0] == BASE_ADDR[0]);
  assign strb_set_o = wbit_i;
  assign rd_hit_o   = rd_i && pair_hit;
  assign rd_sel_o   = addr_i[0] ^ BASE_ADDR[0];
endmodule

// File: rtl/pad_strobe_ctl.sv
module pad_strobe_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_wr_i,
  input  logic strb_set_i,
  output logic strobe_o,
  output logic load_o,
  output logic clr_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        strobe_q <= 1'b0;
    else if (strb_wr_i) strobe_q <= strb_set_i;
  end

  assign strobe_o = strobe_q;
  assign clr_o    = strb_wr_i && !strb_set_i;
  // capture only on active -> inactive
  assign load_o   = clr_o && strobe_q;

  // R3
  load_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !strobe_q);
  // R2
  strobe_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_wr_i && strb_set_i) |=> strobe_q);
endmodule

// File: rtl/pad_shift_chan.sv
module pad_shift_chan
  import pad_port_pkg::*;
#(
  parameter int unsigned BTN_N = PAD_BTN_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BTN_N-1:0] btn_i,
  input  logic             strobe_i,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic             rd_i,
  output logic             bit_o
);
  localparam int unsigned IDX_W = $clog2(BTN_N + 1);
  localparam int unsigned SEL_W = (BTN_N > 1) ? $clog2(BTN_N) : 1;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BTN_N);

  logic [BTN_N-1:0] shreg_q;
  logic [IDX_W-1:0] idx_q;
  logic             more;

  assign more  = (idx_q < IDX_END);
  assign bit_o = strobe_i ? btn_i[int'(BTN_A)]
               : (more ? shreg_q[idx_q[SEL_W-1:0]] : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      idx_q   <= '0;
    end else begin
      if (load_i) shreg_q <= btn_i;
      if (clr_i)                          idx_q <= '0;
      else if (rd_i && !strobe_i && more) idx_q <= idx_q + 1'b1;
    end
  end

  // R2
  strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !clr_i) |=> $stable(idx_q));
  // R3
  idx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (idx_q == '0));
  // R5
  drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((idx_q == IDX_END) && !clr_i) |=> (idx_q == IDX_END));
  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_END);
  // R9
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(shreg_q));
endmodule

// File: rtl/pad_port_if.sv
module pad_port_if
  import pad_port_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h4016,
  parameter logic [7:0]  BUS_MASK  = 8'hE0,
  parameter int unsigned BTN_N     = PAD_BTN_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  input  logic [BTN_N-1:0] pad0_btn_i,
  input  logic [BTN_N-1:0] pad1_btn_i
);
  localparam int unsigned PORT_N = 2;

  logic strb_wr, strb_set, rd_hit, rd_sel;
  logic strobe, load, clr;
  logic [BTN_N-1:0] btn_arr [PORT_N];
  logic [PORT_N-1:0] chan_rd, chan_bit;
  logic [7:0] rdata_q;

  wire unused_wdata = ^wdata_i[7:1];

  assign btn_arr[0] = pad0_btn_i;
  assign btn_arr[1] = pad1_btn_i;

  pad_bus_decode #(.BASE_ADDR(BASE_ADDR)) i_decode (
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wbit_i     (wdata_i[0]),
    .strb_wr_o  (strb_wr),
    .strb_set_o (strb_set),
    .rd_hit_o   (rd_hit),
    .rd_sel_o   (rd_sel)
  );

  pad_strobe_ctl i_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strb_wr_i  (strb_wr),
    .strb_set_i (strb_set),
    .strobe_o   (strobe),
    .load_o     (load),
    .clr_o      (clr)
  );

  for (genvar g = 0; g < PORT_N; g++) begin : g_chan
    assign chan_rd[g] = rd_hit && (rd_sel == g[0]);
    pad_shift_chan #(.BTN_N(BTN_N)) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .btn_i    (btn_arr[g]),
      .strobe_i (strobe),
      .load_i   (load),
      .clr_i    (clr),
      .rd_i     (chan_rd[g]),
      .bit_o    (chan_bit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= {addr_i[15:9] & BUS_MASK[7:1], chan_bit[rd_sel]};
  end

  assign rdata_o = rdata_q;

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> $stable(rdata_o));
  // R6
  one_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_rd));
  // R7
  open_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> ((rdata_o[7:1] & ~BUS_MASK[7:1]) == 7'd0));
endmodule

// File: tb/test_pad_port_if.sv
module test_pad_port_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic [7:0]  pad0 = '0;
  logic [7:0]  pad1 = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic fired = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  localparam logic [7:0] PAT0 = 8'b0110_1001;
  localparam logic [7:0] PAT1 = 8'b1100_0010;

  always #2 clk = ~clk;

  pad_port_if i_pad_port_if (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .wr_i       (wr),
    .rd_i       (rd),
    .rdata_o    (rdata),
    .pad0_btn_i (pad0),
    .pad1_btn_i (pad1)
  );

  function automatic logic [7:0] exp_byte(input logic b);
    return {7'h20, b};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: a port read launched at a posedge is compared at the next negedge
  always @(posedge clk) fired <= rd && (addr[15:1] == 15'h200B);

  always @(negedge clk) begin
    if (rst_n && fired) begin
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard: unexpected read data %02h", rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(rdata, it.exp, it.tag);
      end
    end
  end

  task automatic bus_rd(input logic [15:0] a, input logic b, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1; wr = 1'b0; wdata = '0;
    sb_q.push_back('{exp: exp_byte(b), tag: tag});
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b0; wr = 1'b1; wdata = d;
  endtask

  task automatic bus_rdwr(input logic [7:0] d, input logic b, input string tag);
    @(negedge clk);
    addr = 16'h4016; rd = 1'b1; wr = 1'b1; wdata = d;
    sb_q.push_back('{exp: exp_byte(b), tag: tag});
  endtask

  task automatic bus_other_rd(input logic [15:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1; wr = 1'b0; wdata = '0;
  endtask

  task automatic set_btn(input logic [7:0] p0, input logic [7:0] p1);
    @(negedge clk);
    pad0 = p0; pad1 = p1; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd = 1'b0; wr = 1'b0;
    end
  endtask

  initial begin
    pad0 = PAT0; pad1 = PAT1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(rdata, 8'h00, "R1 rdata after reset");
    bus_rd(16'h4016, 1'b0, "R1 port1 first read");
    bus_rd(16'h4017, 1'b0, "R1 port2 first read");

    // R2 strobe active: live button A, no advance
    bus_wr(16'h4016, 8'h01);
    bus_rd(16'h4016, PAT0[0], "R2 strobe read A");
    bus_rd(16'h4016, PAT0[0], "R2 strobe repeat");
    bus_rd(16'h4017, PAT1[0], "R2 strobe port2 A");
    set_btn(PAT0 ^ 8'h01, PAT1);
    bus_rd(16'h4016, ~PAT0[0], "R2 live A");
    set_btn(PAT0, PAT1);

    // R3 capture then invert inputs (R9)
    bus_wr(16'h4016, 8'h00);
    set_btn(~PAT0, ~PAT1);
    for (int i = 0; i < 8; i++) begin
      bus_rd(16'h4016, PAT0[i], $sformatf("R4 port1 bit %0d", i));
      if (i == 2) bus_rd(16'h4017, PAT1[0], "R6 port2 independent");
    end
    bus_rd(16'h4016, 1'b1, "R5 drained 1");
    bus_rd(16'h4016, 1'b1, "R5 drained 2");
    bus_rd(16'h4017, PAT1[1], "R6 port2 second bit");

    // R9 rewrite 0 while inactive: index reset, old capture kept
    bus_wr(16'h4016, 8'h00);
    bus_rd(16'h4016, PAT0[0], "R9 old capture bit0");
    bus_rd(16'h4016, PAT0[1], "R9 old capture bit1");
    bus_rd(16'h4017, PAT1[0], "R3 port2 index reset");

    // R8 no effect from other accesses
    bus_other_rd(16'h4015);
    idle(1);
    check(rdata, exp_byte(PAT1[0]), "R8 rdata hold");
    bus_wr(16'h4017, 8'h01);
    bus_wr(16'h4000, 8'h00);
    bus_rd(16'h4016, PAT0[2], "R8 no strobe from 4017");
    bus_rd(16'h4017, PAT1[1], "R8 port2 untouched");

    // R10 read coinciding with strobe write
    bus_wr(16'h4016, 8'h01);
    set_btn(PAT0, PAT1);
    bus_rdwr(8'h00, PAT0[0], "R10 read with clear uses strobe");
    set_btn(~PAT0, ~PAT1);
    bus_rd(16'h4016, PAT0[0], "R10 capture at coinciding write");
    bus_rd(16'h4016, PAT0[1], "R10 bit1");
    bus_rd(16'h4016, PAT0[2], "R10 bit2");
    bus_rdwr(8'h01, PAT0[3], "R10 read with set uses index");
    bus_rd(16'h4016, ~PAT0[0], "R10 strobe now active");
    idle(3);
    if (sb_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d reads got no data, expected 0", sb_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule